// File: doc/BRIEF.md
# Reset Button Hold Timer

This block measures how long an active-low reset button or external reset line stays pressed. The raw pin is asynchronous to the 25 MHz reference clock, so it first passes through a two-stage synchroniser. While the synchronised input shows a press, a saturating counter advances by one on every reference clock. Each count therefore stands for 40 ns, and the default 29-bit width covers about 21.4 s.

When the button is released the counter stops and keeps its value. Software reads that value through a 32-bit length word. The count stays until software writes a clear bit into the same word. A programmable threshold register feeds a comparator that raises a long-press flag when the stored length reaches the threshold. The reset value of the threshold is a whole number of seconds times the count for one second, so boot code can act on the flag to start a factory-reset routine.

Top module: `rst_hold_timer`

## Requirements
- R1: While the synchronised input shows a press (`btn_n` sampled low), the count rises by exactly one on each clock edge.
- R2: The pin passes through two flops before it reaches the counter. The first increment shows on `len_rd` at the third rising edge after `btn_n` falls. A press during which `btn_n` is sampled low on N edges leaves a final count of N.
- R3: The count saturates at 2^CNT_W-1 and holds that value while the press continues. It never wraps.
- R4: After release the count stays unchanged. A later press without a clear goes on counting from the held value.
- R5: A write with `wr_sel`=0 (length word) and `wr_data[31]`=1 zeroes the count on that clock edge. The same write with bit 31 = 0 leaves the count as it was.
- R6: A clear that arrives during a press takes priority over the increment: the count is 0 after that edge and 1 after the next edge.
- R7: `len_rd[CNT_W-1:0]` is the count and all bits above it read as zero. With the default width that is bits 28:0 for the count and bits 31:29 as zero.
- R8: A write with `wr_sel`=1 loads `wr_data[CNT_W-1:0]` into the threshold. `long_press` is registered. It is high one edge after count ≥ threshold holds and low one edge after count < threshold holds.
- R9: Synchronous reset sets the count to 0 and `long_press` to 0. It loads the threshold with HOLD_SEC × REF_HZ (5 s by default), so short presses do not raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | synchronous active-high reset |
| btn_n | input | 1 | asynchronous active-low button / reset pin |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 1 | write target: 0 = length word, 1 = threshold |
| wr_data | input | 32 | write data; bit 31 is the clear bit of the length word |
| len_rd | output | 32 | length word: count in the low CNT_W bits, zeros above |
| long_press | output | 1 | registered flag: stored count ≥ threshold |

## Verification
The count first moves on the third rising edge after the pin falls and stops moving on the second edge after the pin rises. The bench therefore waits three edges after each release before it reads the length. It changes every input on a falling edge and reads every output on a falling edge, so each check sees the settled value of a known edge. A clear takes effect on its own write edge. The long-press flag follows the count by one further edge, so after a clear the bench checks that the flag is still high one half-cycle later and low one full cycle after that. Saturation is checked on a second instance built with a 5-bit counter.

// File: rtl/rst_hold_pkg.sv
package rst_hold_pkg;
  localparam int REG_W   = 32;
  localparam int CLR_BIT = 31;

  typedef enum logic {
    SEL_LEN = 1'b0,
    SEL_THR = 1'b1
  } wsel_e;
endpackage

// File: rtl/rhc_sync.sv
module rhc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_n,
  output logic pressed
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], async_n};
  end

  assign pressed = ~sh[STAGES-1];
endmodule

// File: rtl/rhc_counter.sv
module rhc_counter #(
  parameter int W = 29
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && cnt != MAXV)  cnt <= cnt + W'(1);
  end

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && cnt != MAXV) |=> (cnt == $past(cnt) + W'(1)));

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXV && !clr) |=> (cnt == MAXV));

  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(cnt));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  p_resume_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && inc) |=> (cnt == '0));
endmodule

// File: rtl/rhc_thresh.sv
module rhc_thresh #(
  parameter int             W       = 29,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] cnt,
  output logic         flag
);
  logic [W-1:0] thr;

  always_ff @(posedge clk) begin
    if (rst)     thr <= RST_VAL;
    else if (ld) thr <= ld_val;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (cnt >= thr);
  end

  p_flag_low_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt < thr) |=> !flag);

  p_flag_high_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt >= thr) |=> flag);
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer
  import rst_hold_pkg::*;
#(
  parameter int CNT_W    = 29,
  parameter int REF_HZ   = 25_000_000,
  parameter int HOLD_SEC = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        btn_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] len_rd,
  output logic        long_press
);
  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(REF_HZ * HOLD_SEC);
  localparam int PAD_W = REG_W - CNT_W;

  logic             pressed;
  logic             clr;
  logic             ld;
  logic [CNT_W-1:0] cnt;

  assign clr = wr_en && (wsel_e'(wr_sel) == SEL_LEN) && wr_data[CLR_BIT];
  assign ld  = wr_en && (wsel_e'(wr_sel) == SEL_THR);

  rhc_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_n (btn_n),
    .pressed (pressed)
  );

  rhc_counter #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .inc (pressed),
    .clr (clr),
    .cnt (cnt)
  );

  rhc_thresh #(.W(CNT_W), .RST_VAL(THR_RST)) u_thr (
    .clk    (clk),
    .rst    (rst),
    .ld     (ld),
    .ld_val (wr_data[CNT_W-1:0]),
    .cnt    (cnt),
    .flag   (long_press)
  );

  assign len_rd = {{PAD_W{1'b0}}, cnt};

  p_wr_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && wr_data[CLR_BIT]) |=> (len_rd == 32'd0));

  p_no_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (!pressed && !(wr_en && !wr_sel && wr_data[CLR_BIT])) |=> $stable(len_rd));
endmodule

// File: tb/test_rst_hold_timer.sv
module test_rst_hold_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btn_n = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] len_rd;
  logic        long_press;

  logic        btn_s_n = 1'b1;
  logic [31:0] len_s;
  logic        lp_s;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rst_hold_timer i_rst_hold_timer (
    .clk(clk), .rst(rst), .btn_n(btn_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .len_rd(len_rd), .long_press(long_press)
  );

  rst_hold_timer #(.CNT_W(5)) i_rst_hold_timer_sat (
    .clk(clk), .rst(rst), .btn_n(btn_s_n), .wr_en(1'b0), .wr_sel(1'b0),
    .wr_data(32'd0), .len_rd(len_s), .long_press(lp_s)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic press(input int n);
    @(negedge clk) btn_n = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk) btn_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R9 count after reset", len_rd, 32'd0);
    chk("R9 flag after reset", {31'd0, long_press}, 32'd0);
  endtask

  task automatic t_latency;
    @(negedge clk) btn_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 no count after two edges", len_rd, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 first count on third edge", len_rd, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R1 second increment", len_rd, 32'd2);
    btn_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 final count equals low edges", len_rd, 32'd4);
    wr(1'b0, 32'h8000_0000);
  endtask

  task automatic t_basic;
    press(10);
    chk("R1 ten-cycle press", len_rd, 32'd10);
    chk("R9 default threshold keeps flag low", {31'd0, long_press}, 32'd0);
    chk("R7 upper bits zero", {29'd0, len_rd[31:29]}, 32'd0);
  endtask

  task automatic t_hold;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R4 held after release", len_rd, 32'd10);
    press(5);
    chk("R4 resumes from held value", len_rd, 32'd15);
  endtask

  task automatic t_clear;
    wr(1'b0, 32'h7FFF_FFFF);
    chk("R5 write without bit31 ignored", len_rd, 32'd15);
    wr(1'b0, 32'h8000_0000);
    chk("R5 clear bit zeroes count", len_rd, 32'd0);
  endtask

  task automatic t_clear_during;
    @(negedge clk) btn_n = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h8000_0000;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    chk("R6 clear wins over increment", len_rd, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 counting restarts from zero", len_rd, 32'd1);
    btn_n = 1'b1;
    repeat (3) @(posedge clk);
    wr(1'b0, 32'h8000_0000);
  endtask

  task automatic t_flag;
    wr(1'b1, 32'd8);
    chk("R8 flag low at count 0 thr 8", {31'd0, long_press}, 32'd0);
    press(7);
    chk("R8 count 7", len_rd, 32'd7);
    chk("R8 flag low below threshold", {31'd0, long_press}, 32'd0);
    press(1);
    chk("R8 count 8", len_rd, 32'd8);
    chk("R8 flag high at threshold", {31'd0, long_press}, 32'd1);
    wr(1'b0, 32'h8000_0000);
    chk("R8 count cleared", len_rd, 32'd0);
    chk("R8 flag lags clear by one edge", {31'd0, long_press}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R8 flag drops after clear", {31'd0, long_press}, 32'd0);
  endtask

  task automatic t_sat;
    @(negedge clk) btn_s_n = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R3 saturates while held", len_s, 32'd31);
    btn_s_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 saturated value held", len_s, 32'd31);
    chk("R7 bits above count zero", len_s & 32'hFFFF_FFE0, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_latency();
    t_basic();
    t_hold();
    t_clear();
    t_clear_during();
    t_flag();
    t_sat();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule